// File: doc/BRIEF.md
# Entropy CRC Conditioner with Read Interlock

This block conditions raw noise for a random number generator. Three single-bit noise inputs arrive every clock, and each one is gated by its own enable. The surviving bits are XOR-combined into one bit per cycle. That bit is shifted into a 64-bit CRC register, and the register contents are presented as a read-only 64-bit random word.

A consumer requests a word by raising a read-valid. The read completes on any cycle where both valid and ready are high. When the interlock mode is on, ready stays low until a programmed number of accumulation cycles has gone by since the last completed read. This lets enough fresh entropy mix into the register before the next word is taken. When the interlock mode is off, every read completes at once.

Top module: `entropy_conditioner`

## Requirements
- R1: After reset the data word is all zeros and the cycle counter is zero, so with interlock mode on and a nonzero wait value, ready is low.
- R2: Each clock, the mixed bit is the XOR of the noise bits whose enables are set. The enable bit at index i gates noise input i. A noise input whose enable is clear has no effect on the data word.
- R3: The CRC shifts left by one bit every clock. If the old bit 63 XOR the mixed bit equals 1, the shifted value is XORed with the polynomial's low 64 bits. The polynomial is x^64+x^61+x^57+x^56+x^52+x^51+x^50+x^48+x^47+x^46+x^43+x^42+x^41+x^39+x^38+x^37+x^35+x^32+x^28+x^25+x^22+x^21+x^17+x^15+x^13+x^12+x^11+x^7+x^5+x+1.
- R4: The data output equals the CRC register on every cycle.
- R5: With interlock mode on, ready is high exactly when the number of clock edges since the last completed read (or since reset) is at least the wait value.
- R6: A completed read (valid and ready high together) restarts the cycle count at zero on the next edge.
- R7: With interlock mode off, ready is high on every cycle.
- R8: With interlock mode on and a wait value of zero, ready is high on every cycle.
- R9: The cycle counter saturates at its maximum and does not wrap, so ready stays high during a long idle period even with the largest wait value.
- R10: With all enables clear, the mixed bit is 0, and a zero CRC state stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_i | input | 3 | Raw noise bits, one per source |
| src_en_i | input | 3 | Per-source enables |
| lock_mode_i | input | 1 | 1 = read interlock active |
| wait_cycles_i | input | 8 | Minimum cycles between completed reads |
| rd_valid_i | input | 1 | Read request |
| rd_ready_o | output | 1 | Read may complete this cycle |
| rd_data_o | output | 64 | Conditioned random word |

## Verification
The hardest case to reach from the ports is counter saturation. Seeing it takes hundreds of idle cycles with the largest wait value and no read. A directed phase holds valid low for longer than the counter range, then checks that ready stays high and drops again after one read. The other hard case is the boundary cycle where ready first rises. Random phases cover it by keeping wait values small while toggling valid, so reads land on the boundary many times.

// File: rtl/entcond_pkg.sv
package entcond_pkg;
    localparam int CRC_W = 64;
    localparam logic [CRC_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;
    localparam int NUM_SRC = 3;
    localparam int WAIT_W = 8;
endpackage

// File: rtl/entcond_mixer.sv
module entcond_mixer #(
    parameter int N = 3
) (
    input  logic [N-1:0] noise_i,
    input  logic [N-1:0] en_i,
    output logic         bit_o
);
    logic [N-1:0] gated;
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = noise_i[i] & en_i[i];
    end
    assign bit_o = ^gated;
endmodule

// File: rtl/entcond_crc.sv
module entcond_crc #(
    parameter int W = 64,
    parameter logic [W-1:0] POLY = entcond_pkg::CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    typedef struct packed {
        logic [W-1:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic    fb;

    always_comb begin
        st_d   = st_q;
        fb     = st_q.crc[W-1] ^ bit_i;
        st_d.crc = {st_q.crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o = st_q.crc;

    assert_zero_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.crc == '0 && !bit_i) |=> (st_q.crc == '0));

    assert_plain_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.crc[W-1] && !bit_i) |=> (st_q.crc == {$past(st_q.crc[W-2:0]), 1'b0}));
endmodule

// File: rtl/entcond_interlock.sv
module entcond_interlock #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] wait_i,
    input  logic             valid_i,
    output logic             ready_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     fire;

    assign ready_o = !mode_i || (st_q.cnt >= wait_i);
    assign fire    = valid_i && ready_o;

    always_comb begin
        st_d = st_q;
        if (fire)                st_d.cnt = '0;
        else if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.cnt == '0));

    assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_i && wait_i != '0) |=> (!mode_i || wait_i == '0 || !ready_o));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '1 && !fire) |=> (st_q.cnt == '1));
endmodule

// File: rtl/entropy_conditioner.sv
module entropy_conditioner #(
    parameter int NSRC  = entcond_pkg::NUM_SRC,
    parameter int WBITS = entcond_pkg::WAIT_W,
    localparam int DW   = entcond_pkg::CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  noise_i,
    input  logic [NSRC-1:0]  src_en_i,
    input  logic             lock_mode_i,
    input  logic [WBITS-1:0] wait_cycles_i,
    input  logic             rd_valid_i,
    output logic             rd_ready_o,
    output logic [DW-1:0]    rd_data_o
);
    logic mix_bit;

    entcond_mixer #(.N(NSRC)) u_mix (
        .noise_i (noise_i),
        .en_i    (src_en_i),
        .bit_o   (mix_bit)
    );

    entcond_crc #(.W(DW), .POLY(entcond_pkg::CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (mix_bit),
        .crc_o (rd_data_o)
    );

    entcond_interlock #(.CNT_W(WBITS)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (lock_mode_i),
        .wait_i  (wait_cycles_i),
        .valid_i (rd_valid_i),
        .ready_o (rd_ready_o)
    );

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en_i == '0 && rd_data_o == '0) |=> (rd_data_o == '0));
endmodule

// File: tb/entropy_conditioner_test.sv
module entropy_conditioner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  noise = '0;
    logic [2:0]  en = '0;
    logic        mode = 1'b0;
    logic [7:0]  wcyc = '0;
    logic        valid = 1'b0;
    logic        ready;
    logic [63:0] data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [63:0] exp_crc;
    int          exp_cnt;
    logic [63:0] poly;

    always #5 clk = ~clk;

    entropy_conditioner uut (
        .clk(clk), .rst_n(rst_n), .noise_i(noise), .src_en_i(en),
        .lock_mode_i(mode), .wait_cycles_i(wcyc), .rd_valid_i(valid),
        .rd_ready_o(ready), .rd_data_o(data)
    );

    function automatic logic [63:0] build_poly();
        int exps[30] = '{61,57,56,52,51,50,48,47,46,43,42,41,39,38,37,
                         35,32,28,25,22,21,17,15,13,12,11,7,5,1,0};
        logic [63:0] p = '0;
        foreach (exps[k]) p[exps[k]] = 1'b1;
        return p;
    endfunction

    function automatic logic [63:0] crc_step(logic [63:0] s, logic b);
        logic f = s[63] ^ b;
        logic [63:0] n = s << 1;
        if (f) n = n ^ poly;
        return n;
    endfunction

    function automatic logic exp_ready();
        return !mode || (exp_cnt >= int'(wcyc));
    endfunction

    task automatic check_val(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // one clock: check outputs for current inputs, advance model, move to next negedge
    task automatic step(string dtag, string rtag);
        logic b;
        logic fire;
        #1;
        check_val(dtag, data, exp_crc);
        check_val(rtag, {63'd0, ready}, {63'd0, exp_ready()});
        b    = ^(noise & en);
        fire = valid && exp_ready();
        exp_crc = crc_step(exp_crc, b);
        if (fire) exp_cnt = 0;
        else if (exp_cnt != 255) exp_cnt++;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        poly = build_poly();
        exp_crc = '0;
        exp_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state with interlock on
        mode = 1; wcyc = 5; en = 3'b111;
        step("R1 data after reset", "R1 ready after reset");
        // R5: ready rises exactly after wait cycles
        for (int i = 0; i < 6; i++) step("R4 data", "R5 ready boundary");

        // R3 directed: from zero with a single 1 input gives POLY
        rst_n = 0; @(negedge clk); rst_n = 1; exp_crc = '0; exp_cnt = 0;
        en = 3'b001; noise = 3'b001; mode = 0;
        step("R3 first shift", "R7 ready unlocked");
        check_val("R3 poly value", data, poly);
        noise = 3'b000;
        for (int i = 0; i < 4; i++) step("R3 shift", "R7 ready unlocked");

        // R10: all disabled from zero stays zero
        rst_n = 0; @(negedge clk); rst_n = 1; exp_crc = '0; exp_cnt = 0;
        en = 3'b000;
        for (int i = 0; i < 6; i++) begin
            noise = 3'($urandom);
            step("R10 zero hold", "R7 ready unlocked");
        end
        check_val("R10 final zero", data, 64'd0);

        // R2: disabled sources toggled freely
        en = 3'b010; noise = 3'b010; step("R2 seed", "R7 ready");
        for (int i = 0; i < 40; i++) begin
            noise = 3'($urandom);
            step("R2 gated mix", "R7 ready");
        end

        // R8: wait zero in interlock mode
        mode = 1; wcyc = 0; en = 3'b111;
        for (int i = 0; i < 20; i++) begin
            noise = 3'($urandom); valid = 1'($urandom);
            step("R4 data", "R8 ready wait zero");
        end

        // R5/R6 random interlock traffic
        for (int i = 0; i < 3000; i++) begin
            noise = 3'($urandom);
            valid = 1'($urandom);
            if (($urandom % 50) == 0) en = 3'($urandom);
            if (($urandom % 40) == 0) wcyc = 8'($urandom % 13);
            if (($urandom % 60) == 0) mode = 1'($urandom);
            step("R3 random crc", "R6 random interlock");
        end

        // R9: saturation with largest wait
        mode = 1; wcyc = 8'd255; valid = 1;
        while (!exp_ready()) begin valid = 0; step("R4 data", "R5 wait long"); end
        valid = 1; step("R4 data", "R6 read fires");
        valid = 0;
        for (int i = 0; i < 300; i++) begin
            noise = 3'($urandom);
            step("R4 data", "R9 saturate idle");
        end
        check_val("R9 ready after idle", {63'd0, ready}, 64'd1);
        valid = 1; step("R4 data", "R6 read after idle");
        valid = 0; step("R4 data", "R6 restart low");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule